// File: doc/BRIEF.md
# Parallel Bit Extract Unit

This functional unit takes a data word and a mask word. It collects the data bits that sit under the mask's one-bits and packs them at the low end of the result. The packing keeps the selected bits in their original order. All result bits above the number of selected bits are zero.

The bits move through an inverse butterfly network of log2(W) swap stages. The stages run from the pair distance of 1 up to W/2. Each stage has W/2 two-input swap switches. By default a decoder sets the switches at run time from the mask. The decoder uses the running population count of the mask below each subnetwork, taken modulo that subnetwork's size.

A mode input can bypass the decoder. In that mode the caller supplies the complete switch-control word, computed ahead of time. The result is registered once, so an operation presented with a valid strobe appears on the next clock cycle.

Top module: `gather_unit`

## Requirements
- R1: In decoder mode (`in_static`=0), result bit j equals the data bit under the (j+1)-th lowest one-bit of the mask, for every j below the number of mask one-bits.
- R2: In decoder mode, every result bit at or above the mask's population count is zero.
- R3: An all-zero mask gives a zero result in either mode. An all-ones mask in decoder mode returns the data unchanged.
- R4: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and `out_result` carries that operation's result in the same cycle.
- R5: A cycle with `in_valid` low leaves `out_result` unchanged on the next clock and drives `out_valid` low; the data, mask and mode inputs of that cycle have no effect.
- R6: In bypass mode (`in_static`=1), the input to the network is data AND mask. Stages run for k = 0 first up to log2(W)-1. Stage k swaps positions i and i+2^k (bit k of i clear) when control bit k*(W/2)+q of `in_ctrl` is one, where q = (i>>(k+1))*2^k + (i mod 2^k).
- R7: In decoder mode `in_ctrl` has no effect on the result.
- R8: While `rst_n` is low, `out_valid` and `out_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_static | input | 1 | 1: use `in_ctrl` as switch controls; 0: use the mask decoder |
| in_data | input | W | Source data word |
| in_mask | input | W | Selection mask |
| in_ctrl | input | log2(W)*W/2 | Precomputed switch controls, stage-major |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | W | Packed result |

## Verification
The assertions assume that `in_static` and the mask are stable and meaningful in any cycle with `in_valid` high. They also assume that the properties on packing and upper-bit zeroing apply only to decoder-mode operations, because arbitrary bypass controls can place bits anywhere. The stimulus drives every input on the falling edge and holds it across the rising edge. It drops `in_valid` after each operation, and it tags each operation with a single mode. Bypass-mode operations are checked against a swap-by-swap model of the network rather than against the packing rule.

// File: rtl/gather_unit.sv
module gather_unit #(
  parameter int W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_static,
  input  logic [W-1:0]                in_data,
  input  logic [W-1:0]                in_mask,
  input  logic [$clog2(W)*(W/2)-1:0]  in_ctrl,
  output logic                        out_valid,
  output logic [W-1:0]                out_result
);
  localparam int LG   = $clog2(W);
  localparam int HALF = W / 2;
  localparam int CW   = LG + 1;
  localparam int NSW  = LG * HALF;

  logic [CW-1:0]  pc [W+1];
  logic [NSW-1:0] dyn_sw, sel_sw;
  logic [W-1:0]   net_out;

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      pc[i] = acc;
      acc   = acc + CW'(in_mask[i]);
    end
    pc[W] = acc;
  end

  always_comb begin
    logic [CW-1:0] md, cl, cu, t_up, t_lo;
    int d, b, s;
    md = '0; cl = '0; cu = '0; t_up = '0; t_lo = '0;
    d = 0; b = 0; s = 0;
    dyn_sw = '0;
    for (int k = 0; k < LG; k++) begin
      for (int q = 0; q < HALF; q++) begin
        d    = 1 << k;
        b    = (q / d) * 2 * d;
        s    = q % d;
        md   = CW'(2 * d - 1);
        cl   = pc[b + d] - pc[b];
        cu   = pc[b + 2 * d] - pc[b + d];
        t_up = (CW'(s) - pc[b + d]) & md;
        t_lo = (CW'(s + d) - pc[b]) & md;
        dyn_sw[k * HALF + q] = (t_up < cu) || (t_lo < cl);
      end
    end
  end

  assign sel_sw = in_static ? in_ctrl : dyn_sw;

  always_comb begin
    logic [W-1:0] v;
    logic tmp;
    int d, i;
    v = in_data & in_mask;
    tmp = 1'b0; d = 0; i = 0;
    for (int k = 0; k < LG; k++) begin
      for (int q = 0; q < HALF; q++) begin
        d = 1 << k;
        i = (q / d) * 2 * d + (q % d);
        if (sel_sw[k * HALF + q]) begin
          tmp      = v[i];
          v[i]     = v[i + d];
          v[i + d] = tmp;
        end
      end
    end
    net_out = v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= net_out;
    end
  end
endmodule

// File: rtl/gather_unit_chk.sv
module gather_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_static,
  input logic [W-1:0] in_data,
  input logic [W-1:0] in_mask,
  input logic         out_valid,
  input logic [W-1:0] out_result
);
  a_r4_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_static) |=> ((out_result >> $past($countones(in_mask))) == '0));

  a_r1_popcount_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_static) |=> ($countones(out_result) == $past($countones(in_data & in_mask))));

  a_r3_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mask == '0) |=> (out_result == '0));

  a_r3_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_static && (&in_mask)) |=> (out_result == $past(in_data)));
endmodule

bind gather_unit gather_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_static(in_static),
  .in_data(in_data), .in_mask(in_mask), .out_valid(out_valid), .out_result(out_result)
);

// File: tb/gather_unit_bench.sv
`timescale 1ns/1ps
module gather_unit_bench;
  localparam int W    = 32;
  localparam int LG   = 5;
  localparam int HALF = W / 2;
  localparam int NSW  = LG * HALF;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_static = 1'b0;
  logic [W-1:0]   in_data = '0;
  logic [W-1:0]   in_mask = '0;
  logic [NSW-1:0] in_ctrl = '0;
  logic           out_valid;
  logic [W-1:0]   out_result;

  int n_chk = 0;
  int n_fail = 0;

  gather_unit #(.W(W)) u_gather_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_static(in_static),
    .in_data(in_data), .in_mask(in_mask), .in_ctrl(in_ctrl),
    .out_valid(out_valid), .out_result(out_result)
  );

  always #2 clk = ~clk;

  localparam logic [95:0] VEC [9] = '{
    {32'hFFFF_FFFF, 32'h0000_00F0, 32'h0000_000F},
    {32'h1234_5678, 32'hFFFF_FFFF, 32'h1234_5678},
    {32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0000},
    {32'hA5A5_A5A5, 32'hFFFF_0000, 32'h0000_A5A5},
    {32'h0000_00AA, 32'h0000_00AA, 32'h0000_000F},
    {32'h0000_00AA, 32'h0000_0055, 32'h0000_0000},
    {32'h8000_0001, 32'h8000_0001, 32'h0000_0003},
    {32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0000_F0F0}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_gather(input logic [W-1:0] d, input logic [W-1:0] m);
    logic [W-1:0] r;
    int n;
    r = '0; n = 0;
    for (int i = 0; i < W; i++)
      if (m[i]) begin r[n] = d[i]; n++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_net(input logic [W-1:0] d, input logic [NSW-1:0] c);
    logic [W-1:0] v;
    logic t;
    int q;
    v = d;
    for (int k = 0; k < LG; k++)
      for (int i = 0; i < W; i++)
        if (((i >> k) & 1) == 0) begin
          q = (i >> (k + 1)) * (1 << k) + (i % (1 << k));
          if (c[k * HALF + q]) begin
            t = v[i]; v[i] = v[i + (1 << k)]; v[i + (1 << k)] = t;
          end
        end
    return v;
  endfunction

  task automatic run_op(input logic st, input logic [W-1:0] d, input logic [W-1:0] m,
                        input logic [NSW-1:0] c, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_static = st; in_data = d; in_mask = m; in_ctrl = c;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R4 valid"}, W'(out_valid), W'(1));
    chk(tag, out_result, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [W-1:0] d, m, e;
    logic [NSW-1:0] c;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", W'(out_valid), W'(0));
    chk("R8 result in reset", out_result, '0);
    rst_n = 1'b1;

    // R1 R2 R3 table of directed vectors
    for (int n = 0; n < 9; n++)
      run_op(1'b0, VEC[n][95:64], VEC[n][63:32], '0, VEC[n][31:0], "R1 R2 R3 table");

    // R3 zero mask in bypass mode
    run_op(1'b1, 32'hCAFE_F00D, '0, {NSW{1'b1}}, '0, "R3 zero mask bypass");

    // R1 R2 R7 random data, masks and ignored controls
    for (int n = 0; n < 400; n++) begin
      d = $urandom; m = $urandom;
      if (n % 4 == 1) m = m & $urandom;
      if (n % 4 == 2) m = m | $urandom;
      c = {$urandom, $urandom, $urandom};
      run_op(1'b0, d, m, c, ref_gather(d, m), "R1 R7 random");
    end

    // R6 bypass mode against the swap-by-swap model
    run_op(1'b1, 32'h1357_9BDF, 32'h00FF_00FF, '0, 32'h0057_00DF, "R6 identity controls");
    for (int n = 0; n < 200; n++) begin
      d = $urandom; m = $urandom;
      c = {$urandom, $urandom, $urandom};
      run_op(1'b1, d, m, c, ref_net(d & m, c), "R6 random controls");
    end

    // R5 idle cycle holds result and ignores inputs
    run_op(1'b0, 32'h0000_FFFF, 32'h0000_0F00, '0, 32'h0000_000F, "R5 setup");
    in_data = 32'hFFFF_FFFF; in_mask = 32'hFFFF_FFFF; in_static = 1'b1;
    @(negedge clk);
    chk("R5 valid low", W'(out_valid), W'(0));
    chk("R5 result held", out_result, 32'h0000_000F);
    @(negedge clk);
    chk("R5 result still held", out_result, 32'h0000_000F);

    // R3 single bit masks at both ends
    run_op(1'b0, 32'h8000_0000, 32'h8000_0000, '0, 32'h0000_0001, "R3 top bit");
    run_op(1'b0, 32'hFFFF_FFFE, 32'h0000_0001, '0, 32'h0000_0000, "R3 bottom zero bit");

    // R8 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 valid after reset", W'(out_valid), W'(0));
    chk("R8 result after reset", out_result, '0);
    @(negedge clk);
    rst_n = 1'b1;
    e = ref_gather(32'h0F0F_1234, 32'h3333_CCCC);
    run_op(1'b0, 32'h0F0F_1234, 32'h3333_CCCC, '0, e, "R1 after reset");

    summary();
  end
endmodule